// File: doc/BRIEF.md
# Infrared Transceiver Mode Programming Sequencer

This block sits on the host side of an infrared transceiver. It owns two pins: the transceiver's shutdown input and its IrDA transmit input. A command selects one of the following: the slow IrDA rate (SIR), the fast IrDA rates (MIR/FIR), remote-control drive (RC), full shutdown, or wake. Commands arrive over a valid/ready handshake. The sequencer then plays out the timed pattern that the transceiver latches on these two pins. While the pattern runs, the data path's transmit bit is kept off the pin. When the pattern ends, the block pulses a done flag and gives the transmit pin back to the data path.

All waits are cycle counts. They are computed by ceiling division from a clock-frequency parameter and nanosecond parameters. A programming pulse on the shutdown pin that lasts too long would be taken as a real shutdown. For that reason the longest such pulse is checked against its limit at elaboration.

The machine has nine states. ST_IDLE accepts commands. ST_SD_LEAD raises shutdown with transmit low. ST_TX_LEAD raises transmit under shutdown (MIR/FIR). ST_RC_PULSE drives the remote-control transmit pulse under shutdown. ST_RC_TAIL drops transmit while shutdown stays high. ST_HOLD_HI drops shutdown with transmit still high. ST_HOLD_LO drops shutdown with transmit low. ST_SHUT_HOLD holds the long shutdown pulse. ST_DONE pulses done for one cycle.

The transitions are as follows:
- IDLE→SD_LEAD: SIR, MIR/FIR or RC command while awake.
- IDLE→SHUT_HOLD: shutdown command while awake.
- IDLE→HOLD_LO: wake command while shut down.
- IDLE→DONE: any ignored command.
- SD_LEAD→HOLD_LO: SIR.
- SD_LEAD→TX_LEAD: MIR/FIR.
- SD_LEAD→RC_PULSE: RC.
- TX_LEAD→HOLD_HI.
- RC_PULSE→RC_TAIL→HOLD_LO.
- HOLD_HI→DONE, HOLD_LO→DONE and SHUT_HOLD→DONE.
- DONE→IDLE.

Each timed state lasts exactly its cycle count.

Top module: `irx_mode_seq`

## Requirements
- R1: After reset the block shows the following: cmd_ready is 1, sd_pin is 0, done is 0 and mode_o is 0 (SIR).
- R2: Command code 0 (SIR) issued while awake gives the following pattern. The shutdown pin goes high with transmit low for ceil(50 ns) cycles. Then both pins are low for ceil(50 ns) cycles. Then comes the done cycle. At 50 MHz this is 3, 3 and 1 cycles. mode_o becomes 0.
- R3: Command code 1 (MIR/FIR) gives the following pattern: shutdown high, transmit low for ceil(200 ns); both high for ceil(50 ns); shutdown low, transmit high for ceil(50 ns); then the done cycle with transmit low. At 50 MHz this is 10, 3, 3 and 1 cycles. mode_o becomes 1. The transmit pin never falls in the same cycle in which the shutdown pin falls.
- R4: Command code 2 (RC) gives the following pattern. Shutdown is high with transmit low for ceil(200 ns). Then both are high for ceil(200 ns). Then shutdown stays high with transmit low for ceil(50 ns). Then both are low for ceil(50 ns). Then comes the done cycle. At 50 MHz this is 10, 10, 3, 3 and 1 cycles. mode_o becomes 2.
- R5: No programming sequence holds the shutdown pin high for more than ceil(5 µs) consecutive cycles (250 at 50 MHz). Parameters that would violate this are rejected at elaboration.
- R6: Command code 3 (shutdown) issued while awake drives the pins as follows. The shutdown pin is held high with transmit low for ceil(30 µs) cycles (1500 at 50 MHz), and then for the done cycle. After that the shutdown pin stays high and mode_o reads 3.
- R7: Command code 4 (wake) issued while shut down lowers the shutdown pin. Both pins are low for ceil(50 ns) cycles before the done cycle. mode_o becomes 0 (SIR).
- R8: cmd_ready is low from the cycle after a command is accepted until the cycle after done. A command held valid during that time is accepted in the first cycle in which ready returns.
- R9: While idle and not shut down, the transmit pin follows tx_data. During a sequence, and while shut down, tx_data has no effect on the transmit pin.
- R10: done is high for exactly one cycle per accepted command. mode_o changes only in that cycle.
- R11: Some commands are ignored: codes 0 to 3 issued while shut down, code 4 issued while awake, and codes 5 to 7. An ignored command produces only the done cycle. It changes neither the pins nor mode_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_code | input | 3 | 0 SIR, 1 MIR/FIR, 2 RC, 3 shutdown, 4 wake |
| cmd_ready | output | 1 | High when a command can be accepted |
| tx_data | input | 1 | Transmit bit from the data path |
| sd_pin | output | 1 | Transceiver shutdown pin, active high |
| txir_pin | output | 1 | Transceiver IrDA transmit pin, active high |
| done | output | 1 | One-cycle completion pulse |
| mode_o | output | 2 | Programmed mode: 0 SIR, 1 MIR/FIR, 2 RC, 3 shutdown |

## Verification
The hardest situation to reach is the set of ignored commands issued while shut down. The transceiver must first be put through the full 30 µs shutdown pulse, and only after that can a programming command be offered. The bench does this: it shuts down, offers a SIR command, and expects only a done cycle with the shutdown pin still high. It then wakes the block. A second difficult case is a command held valid while busy. The bench raises the next command at once after an accepted one, and the scoreboard expects the second pattern to start right after the single idle cycle.

// File: rtl/irx_mode_pkg.sv
package irx_mode_pkg;

    localparam logic [2:0] CMD_SIR  = 3'd0;
    localparam logic [2:0] CMD_MIR  = 3'd1;
    localparam logic [2:0] CMD_RC   = 3'd2;
    localparam logic [2:0] CMD_SHUT = 3'd3;
    localparam logic [2:0] CMD_WAKE = 3'd4;

    typedef enum logic [1:0] {
        MODE_SIR = 2'd0,
        MODE_MIR = 2'd1,
        MODE_RC  = 2'd2,
        MODE_OFF = 2'd3
    } irx_mode_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SD_LEAD,
        ST_TX_LEAD,
        ST_RC_PULSE,
        ST_RC_TAIL,
        ST_HOLD_HI,
        ST_HOLD_LO,
        ST_SHUT_HOLD,
        ST_DONE
    } irx_state_e;

    // ceil(ns * hz / 1e9), never below one cycle
    function automatic int unsigned ns_to_cycles(longint unsigned ns, longint unsigned hz);
        longint unsigned c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        if (c == 0) c = 1;
        return int'(c);
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/irx_mode_timer.sv
module irx_mode_timer #(
    parameter int unsigned W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/irx_pin_mux.sv
module irx_pin_mux (
    input  logic seq_own,
    input  logic seq_sd,
    input  logic seq_tx,
    input  logic mode_off,
    input  logic tx_data,
    output logic sd_pin,
    output logic txir_pin
);
    always_comb begin
        if (seq_own) begin
            sd_pin   = seq_sd;
            txir_pin = seq_tx;
        end else begin
            sd_pin   = mode_off;
            txir_pin = mode_off ? 1'b0 : tx_data;
        end
    end
endmodule

// File: rtl/irx_mode_fsm.sv
module irx_mode_fsm
    import irx_mode_pkg::*;
#(
    parameter int unsigned W          = 11,
    parameter int unsigned SIR_LEAD_C = 3,
    parameter int unsigned LEAD_C     = 10,
    parameter int unsigned TXS_C      = 3,
    parameter int unsigned HOLD_C     = 3,
    parameter int unsigned RC_C       = 10,
    parameter int unsigned SHUT_C     = 1500,
    parameter int unsigned PMAX_C     = 250
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_valid,
    input  logic [2:0]   cmd_code,
    input  logic         expired,
    output logic         cmd_ready,
    output logic         load,
    output logic [W-1:0] load_val,
    output logic         seq_own,
    output logic         seq_sd,
    output logic         seq_tx,
    output logic         done,
    output logic [1:0]   mode
);
    irx_state_e state_q, state_d;
    irx_mode_e  mode_q, tgt_q, tgt_d;
    int unsigned dur;
    logic        is_off;

    assign is_off = (mode_q == MODE_OFF);

    // next-state logic
    always_comb begin
        state_d = state_q;
        tgt_d   = tgt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    tgt_d   = mode_q;
                    state_d = ST_DONE;
                    if (cmd_code == CMD_SIR && !is_off) begin
                        tgt_d = MODE_SIR; state_d = ST_SD_LEAD;
                    end else if (cmd_code == CMD_MIR && !is_off) begin
                        tgt_d = MODE_MIR; state_d = ST_SD_LEAD;
                    end else if (cmd_code == CMD_RC && !is_off) begin
                        tgt_d = MODE_RC;  state_d = ST_SD_LEAD;
                    end else if (cmd_code == CMD_SHUT && !is_off) begin
                        tgt_d = MODE_OFF; state_d = ST_SHUT_HOLD;
                    end else if (cmd_code == CMD_WAKE && is_off) begin
                        tgt_d = MODE_SIR; state_d = ST_HOLD_LO;
                    end
                end
            end
            ST_SD_LEAD: if (expired) begin
                if (tgt_q == MODE_SIR)      state_d = ST_HOLD_LO;
                else if (tgt_q == MODE_MIR) state_d = ST_TX_LEAD;
                else                        state_d = ST_RC_PULSE;
            end
            ST_TX_LEAD:   if (expired) state_d = ST_HOLD_HI;
            ST_RC_PULSE:  if (expired) state_d = ST_RC_TAIL;
            ST_RC_TAIL:   if (expired) state_d = ST_HOLD_LO;
            ST_HOLD_HI:   if (expired) state_d = ST_DONE;
            ST_HOLD_LO:   if (expired) state_d = ST_DONE;
            ST_SHUT_HOLD: if (expired) state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // duration of the state being entered
    always_comb begin
        unique case (state_d)
            ST_SD_LEAD:   dur = (tgt_d == MODE_SIR) ? SIR_LEAD_C : LEAD_C;
            ST_TX_LEAD:   dur = TXS_C;
            ST_RC_PULSE:  dur = RC_C;
            ST_RC_TAIL:   dur = HOLD_C;
            ST_HOLD_HI:   dur = HOLD_C;
            ST_HOLD_LO:   dur = HOLD_C;
            ST_SHUT_HOLD: dur = SHUT_C;
            default:      dur = 1;
        endcase
    end

    assign load     = (state_d != state_q);
    assign load_val = W'(dur - 1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tgt_q   <= MODE_SIR;
            mode_q  <= MODE_SIR;
        end else begin
            state_q <= state_d;
            tgt_q   <= tgt_d;
            if (state_d == ST_DONE && state_q != ST_DONE) mode_q <= tgt_d;
        end
    end

    // outputs
    always_comb begin
        seq_sd = 1'b0;
        seq_tx = 1'b0;
        unique case (state_q)
            ST_SD_LEAD:   seq_sd = 1'b1;
            ST_TX_LEAD:   begin seq_sd = 1'b1; seq_tx = 1'b1; end
            ST_RC_PULSE:  begin seq_sd = 1'b1; seq_tx = 1'b1; end
            ST_RC_TAIL:   seq_sd = 1'b1;
            ST_HOLD_HI:   seq_tx = 1'b1;
            ST_SHUT_HOLD: seq_sd = 1'b1;
            ST_DONE:      seq_sd = is_off;
            default:      ;
        endcase
        seq_own   = (state_q != ST_IDLE);
        cmd_ready = (state_q == ST_IDLE);
        done      = (state_q == ST_DONE);
        mode      = mode_q;
    end

    // run length of the shutdown pin, for the checks below
    logic [W:0] sd_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sd_run_q <= '0;
        else if (seq_sd && seq_own) sd_run_q <= sd_run_q + 1'b1;
        else sd_run_q <= '0;
    end

    p_prog_sd_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_SD_LEAD, ST_TX_LEAD, ST_RC_PULSE, ST_RC_TAIL})
        |-> (sd_run_q < (W+1)'(PMAX_C)));

    p_shut_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHUT_HOLD && state_d == ST_DONE)
        |-> (sd_run_q >= (W+1)'(SHUT_C - 1)));

    p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && cmd_ready));
endmodule

// File: rtl/irx_mode_seq.sv
module irx_mode_seq
    import irx_mode_pkg::*;
#(
    parameter longint unsigned CLK_HZ      = 50_000_000,
    parameter longint unsigned SD_LEAD_NS  = 200,
    parameter longint unsigned TX_SETUP_NS = 50,
    parameter longint unsigned HOLD_NS     = 50,
    parameter longint unsigned RC_PULSE_NS = 200,
    parameter longint unsigned SHUT_NS     = 30_000,
    parameter longint unsigned PROG_MAX_NS = 5_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_code,
    output logic       cmd_ready,
    input  logic       tx_data,
    output logic       sd_pin,
    output logic       txir_pin,
    output logic       done,
    output logic [1:0] mode_o
);
    localparam int unsigned LEAD_C   = ns_to_cycles(SD_LEAD_NS, CLK_HZ);
    localparam int unsigned TXS_C    = ns_to_cycles(TX_SETUP_NS, CLK_HZ);
    localparam int unsigned HOLD_C   = ns_to_cycles(HOLD_NS, CLK_HZ);
    localparam int unsigned RC_C     = ns_to_cycles(RC_PULSE_NS, CLK_HZ);
    localparam int unsigned SHUT_C   = ns_to_cycles(SHUT_NS, CLK_HZ);
    localparam int unsigned PMAX_C   = ns_to_cycles(PROG_MAX_NS, CLK_HZ);
    localparam int unsigned SIR_SD_C = TXS_C;
    localparam int unsigned MIR_SD_C = LEAD_C + TXS_C;
    localparam int unsigned RC_SD_C  = LEAD_C + RC_C + HOLD_C;
    localparam int unsigned PROG_SD_C = max2(SIR_SD_C, max2(MIR_SD_C, RC_SD_C));
    localparam int unsigned MAX_C    = max2(SHUT_C, max2(LEAD_C, max2(RC_C, max2(TXS_C, HOLD_C))));
    localparam int unsigned W        = $clog2(MAX_C + 1);

    generate
        if (PROG_SD_C > PMAX_C) begin : g_prog_pulse_too_long
            $error("programming pulse on shutdown pin exceeds its maximum");
        end
        if (SHUT_C <= PMAX_C) begin : g_shut_pulse_too_short
            $error("shutdown pulse must exceed the programming maximum");
        end
    endgenerate

    logic         load, expired, seq_own, seq_sd, seq_tx;
    logic [W-1:0] load_val;

    irx_mode_timer #(.W(W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    irx_mode_fsm #(
        .W(W), .SIR_LEAD_C(SIR_SD_C), .LEAD_C(LEAD_C), .TXS_C(TXS_C),
        .HOLD_C(HOLD_C), .RC_C(RC_C), .SHUT_C(SHUT_C), .PMAX_C(PMAX_C)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .expired   (expired),
        .cmd_ready (cmd_ready),
        .load      (load),
        .load_val  (load_val),
        .seq_own   (seq_own),
        .seq_sd    (seq_sd),
        .seq_tx    (seq_tx),
        .done      (done),
        .mode      (mode_o)
    );

    irx_pin_mux u_mux (
        .seq_own  (seq_own),
        .seq_sd   (seq_sd),
        .seq_tx   (seq_tx),
        .mode_off (mode_o == MODE_OFF),
        .tx_data  (tx_data),
        .sd_pin   (sd_pin),
        .txir_pin (txir_pin)
    );

    p_tx_outlasts_sd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sd_pin) && $past(txir_pin)) |-> txir_pin);

    p_mode_moves_on_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_o) |-> done);

    p_off_tx_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && mode_o == 2'd3) |-> (sd_pin && !txir_pin));
endmodule

// File: tb/tb_irx_mode_seq.sv
module tb_irx_mode_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_code = 3'd0;
    logic       tx_data = 1'b0;
    logic       cmd_ready, sd_pin, txir_pin, done;
    logic [1:0] mode_o;

    always #10 clk = ~clk;

    irx_mode_seq dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_ready(cmd_ready), .tx_data(tx_data), .sd_pin(sd_pin),
        .txir_pin(txir_pin), .done(done), .mode_o(mode_o)
    );

    // expected cycle counts at a 20 ns period, ceiling of ns/20
    function automatic int cyc(int ns);
        return (ns + 19) / 20;
    endfunction

    typedef struct {
        logic [2:0] key;  // {sd, tx, done}
        int         len;
        string      tag;
    } seg_t;

    seg_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    logic mon_en = 1'b0;
    logic [2:0] cur_key;
    int   run_len = 0;
    int   sd_run = 0;
    int   sd_max = 0;
    logic track_sd = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic [2:0] key, input int len, input string tag);
        seg_t s;
        s.key = key; s.len = len; s.tag = tag;
        exp_q.push_back(s);
    endtask

    task automatic close_seg();
        seg_t s;
        if (exp_q.size() == 0) begin
            check(1'b0, "unexpected segment", int'(cur_key), -1);
        end else begin
            s = exp_q.pop_front();
            check(s.key == cur_key, {s.tag, " pins"}, int'(cur_key), int'(s.key));
            check(s.len == run_len, {s.tag, " length"}, run_len, s.len);
        end
    endtask

    // monitor: segment the busy period into runs of {sd, tx, done}
    always @(negedge clk) begin
        if (mon_en) begin
            if (track_sd) begin
                if (sd_pin) sd_run++; else sd_run = 0;
                if (sd_run > sd_max) sd_max = sd_run;
            end
            if (!cmd_ready) begin
                if (run_len > 0 && {sd_pin, txir_pin, done} == cur_key) begin
                    run_len++;
                end else begin
                    if (run_len > 0) close_seg();
                    cur_key = {sd_pin, txir_pin, done};
                    run_len = 1;
                end
            end else if (run_len > 0) begin
                close_seg();
                run_len = 0;
            end
        end
    end

    task automatic issue(input logic [2:0] code);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = code;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic settle();
        while (exp_q.size() != 0 || !cmd_ready || run_len != 0) @(negedge clk);
        @(negedge clk);
    endtask

    localparam int C50  = 3;
    localparam int C200 = 10;

    initial begin : watchdog
        repeat (200_000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
        check(sd_pin == 1'b0,    "R1 sd",    sd_pin, 0);
        check(done == 1'b0,      "R1 done",  done, 0);
        check(mode_o == 2'd0,    "R1 mode",  mode_o, 0);
        check(cyc(50) == C50 && cyc(200) == C200, "cycle table", cyc(50), C50);
        mon_en   = 1'b1;
        track_sd = 1'b1;

        // R9 idle passthrough
        tx_data = 1'b1; #1;
        check(txir_pin == 1'b1, "R9 idle follow high", txir_pin, 1);
        tx_data = 1'b0; #1;
        check(txir_pin == 1'b0, "R9 idle follow low", txir_pin, 0);

        // R2 SIR, with tx_data high to show it is blocked (R9)
        tx_data = 1'b1;
        push(3'b100, cyc(50), "R2 sd lead");
        push(3'b000, cyc(50), "R2/R9 hold low");
        push(3'b001, 1,       "R2 done");
        issue(3'd0);
        settle();
        tx_data = 1'b0;
        check(mode_o == 2'd0, "R2 mode", mode_o, 0);

        // R3 MIR/FIR
        push(3'b100, cyc(200), "R3 sd lead");
        push(3'b110, cyc(50),  "R3 tx setup");
        push(3'b010, cyc(50),  "R3 tx hold");
        push(3'b001, 1,        "R3 done");
        issue(3'd1);
        settle();
        check(mode_o == 2'd1, "R3 mode", mode_o, 1);
        tx_data = 1'b1; #1;
        check(txir_pin == 1'b1, "R9 follow after MIR", txir_pin, 1);
        tx_data = 1'b0;

        // R4 RC
        push(3'b100, cyc(200), "R4 sd lead");
        push(3'b110, cyc(200), "R4 rc pulse");
        push(3'b100, cyc(50),  "R4 tx tail");
        push(3'b000, cyc(50),  "R4 hold low");
        push(3'b001, 1,        "R4 done");
        issue(3'd2);
        settle();
        check(mode_o == 2'd2, "R4 mode", mode_o, 2);

        // R8 back-to-back: SIR, then MIR/FIR held valid while busy
        push(3'b100, cyc(50),  "R8 first lead");
        push(3'b000, cyc(50),  "R8 first hold");
        push(3'b001, 1,        "R8 first done");
        push(3'b100, cyc(200), "R8 second lead");
        push(3'b110, cyc(50),  "R8 second setup");
        push(3'b010, cyc(50),  "R8 second hold");
        push(3'b001, 1,        "R8 second done");
        issue(3'd0);
        check(cmd_ready == 1'b0, "R8 busy ready low", cmd_ready, 0);
        issue(3'd1);
        settle();
        check(mode_o == 2'd1, "R8 mode", mode_o, 1);

        // R11 undefined code and wake while awake
        push(3'b001, 1, "R11 code6 done only");
        issue(3'd6);
        settle();
        check(mode_o == 2'd1, "R11 code6 mode kept", mode_o, 1);
        push(3'b001, 1, "R11 wake awake done only");
        issue(3'd4);
        settle();
        check(mode_o == 2'd1, "R11 wake mode kept", mode_o, 1);

        // R5 programming pulses stayed below the limit
        check(sd_max > 0 && sd_max <= cyc(5000), "R5 max sd run", sd_max, cyc(5000));
        track_sd = 1'b0;

        // R6 shutdown
        push(3'b100, cyc(30000), "R6 shut pulse");
        push(3'b101, 1,          "R6 done");
        issue(3'd3);
        settle();
        check(mode_o == 2'd3, "R6 mode", mode_o, 3);
        check(sd_pin == 1'b1, "R6 sd held", sd_pin, 1);
        tx_data = 1'b1; #1;
        check(txir_pin == 1'b0, "R9 tx blocked in shutdown", txir_pin, 0);

        // R11 programming while shut down is ignored
        push(3'b101, 1, "R11 sir while off done only");
        issue(3'd0);
        settle();
        check(mode_o == 2'd3, "R11 off mode kept", mode_o, 3);
        check(sd_pin == 1'b1, "R11 off sd kept", sd_pin, 1);
        tx_data = 1'b0;

        // R7 wake
        push(3'b000, cyc(50), "R7 wake hold");
        push(3'b001, 1,       "R7 done");
        issue(3'd4);
        settle();
        check(mode_o == 2'd0, "R7 mode", mode_o, 0);
        check(sd_pin == 1'b0, "R7 sd low", sd_pin, 0);
        check(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule